// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes a single load or store from a warp of lanes, where each lane carries its own integer byte address and an active-mask bit, and turns it into the smallest set of aligned block transactions that the memory side has to serve. A block is 64 bytes and is named by the byte address with its low six bits cleared. On every cycle with an unserved lane, the block picks the lowest-numbered unserved active lane as the leader. It then gathers every other unserved, properly aligned lane in the leader's block into one transaction. A lane whose address is not a multiple of its access size is never merged and goes out on its own.

Each transaction carries the block address, a per-lane hit mask, the byte offset of every hit lane inside the block, the access-size code and a sequence tag. The tag lets a memory system with many requests in flight match replies to transactions. Both sides use a valid/ready handshake. A new warp request is taken only once the previous one has been fully emitted, and a request with no active lane is taken and finished at once.

Top module: `warp_coalescer`

## Requirements
- R1: During and after reset, reqReady is 1, txnValid is 0 and txnTag is 0.
- R2: For each lane set in txnLaneMask, its OFF_W-bit field in txnOffsets (lane i at bits i*OFF_W upward) equals the low six bits of that lane's address. Fields of lanes not in the mask are 0.
- R3: A transaction's mask holds the leader (the lowest-numbered unserved active lane) and, if the leader is aligned, every other unserved active aligned lane whose address shares the leader's block address.
- R4: txnBlockAddr is the leader's address with its low six bits cleared. Because each leader is the lowest unserved lane, transactions come out in ascending order of leader lane.
- R5: reqSize encodes the access size: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. A lane is aligned when its address is a multiple of that size. A misaligned lane is emitted alone in a transaction of its own, and is never added to another lane's transaction.
- R6: Lanes with a 0 mask bit never appear in any transaction. A request whose mask is all zero is accepted, produces no transaction, and leaves reqReady at 1 on the next cycle.
- R7: reqReady and txnValid are never both 1. reqReady returns to 1 on the cycle after the handshake of the last transaction of a warp.
- R8: While txnValid is 1 and txnReady is 0, txnValid stays 1 and all transaction fields hold their values.
- R9: txnTag increases by one, modulo 2^TAG_W, after every transaction handshake.
- R10: txnSize equals the reqSize of the warp request being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Warp request present |
| reqReady | output | 1 | Coalescer can accept a warp request |
| reqAddr | input | LANES*ADDR_W | Per-lane byte addresses, lane i at bits i*ADDR_W upward |
| reqMask | input | LANES | Active lanes |
| reqSize | input | 2 | Access-size code |
| txnValid | output | 1 | Block transaction present |
| txnReady | input | 1 | Memory side accepts the transaction |
| txnBlockAddr | output | ADDR_W | Aligned block address |
| txnLaneMask | output | LANES | Lanes served by this transaction |
| txnOffsets | output | LANES*OFF_W | Byte offset inside the block, per lane |
| txnSize | output | 2 | Access-size code of the warp |
| txnTag | output | TAG_W | Transaction sequence tag |

## Verification
The sweeps aim at strides that put lanes just across a block boundary. A design that compares full addresses instead of block addresses, or that clears the wrong number of bits, would split or merge these lanes wrongly. Base offsets that misalign every size code check that misaligned lanes are never merged, and that code 3 is treated as a 4-byte access; a design that merges them would emit too few transactions. Sparse and empty masks check that idle lanes never appear and that an empty warp does not hang the request side. Random back-pressure on txnReady catches a design that advances its pending set or its tag without a handshake.

// File: rtl/coalescer_pkg.sv
package coalescer_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } coalState_t;

  typedef struct packed {
    logic load;     // capture a new warp request
    logic advance;  // current group handed off, retire its lanes
  } coalStrobe_t;
endpackage

// File: rtl/coalescer_datapath.sv
module coalescer_datapath
  import coalescer_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int TAG_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  coalStrobe_t             strobe,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]        reqMask,
  input  logic [1:0]              reqSize,
  output logic                    lastGroup,
  output logic [ADDR_W-1:0]       txnBlockAddr,
  output logic [LANES-1:0]        txnLaneMask,
  output logic [LANES*OFF_W-1:0]  txnOffsets,
  output logic [1:0]              txnSize,
  output logic [TAG_W-1:0]        txnTag
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] addrQ [LANES];
  logic [LANES-1:0]  pendQ;
  logic [1:0]        sizeQ;
  logic [TAG_W-1:0]  tagQ;

  logic [IDX_W-1:0]  leaderIdx;
  logic [BLK_W-1:0]  leadBlock;
  logic              leadAligned;
  logic [LANES-1:0]  laneAligned;
  logic [LANES-1:0]  group;

  // lowest-numbered pending lane wins
  always_comb begin
    leaderIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pendQ[i]) leaderIdx = IDX_W'(i);
    end
  end

  assign leadBlock   = addrQ[leaderIdx][ADDR_W-1:OFF_W];
  assign leadAligned = laneAligned[leaderIdx];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_comb begin
      unique case (sizeQ)
        2'd0:    laneAligned[g] = 1'b1;
        2'd1:    laneAligned[g] = ~addrQ[g][0];
        default: laneAligned[g] = (addrQ[g][1:0] == 2'b00);
      endcase
    end

    always_comb begin
      if (leadAligned)
        group[g] = pendQ[g] && laneAligned[g] &&
                   (addrQ[g][ADDR_W-1:OFF_W] == leadBlock);
      else
        group[g] = pendQ[g] && (leaderIdx == IDX_W'(g));
    end

    assign txnOffsets[g*OFF_W +: OFF_W] = group[g] ? addrQ[g][OFF_W-1:0] : '0;
  end

  assign lastGroup    = ((pendQ & ~group) == '0);
  assign txnBlockAddr = {leadBlock, {OFF_W{1'b0}}};
  assign txnLaneMask  = group;
  assign txnSize      = sizeQ;
  assign txnTag       = tagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      sizeQ <= '0;
      tagQ  <= '0;
    end else if (strobe.load) begin
      pendQ <= reqMask;
      sizeQ <= reqSize;
    end else if (strobe.advance) begin
      pendQ <= pendQ & ~group;
      tagQ  <= tagQ + {{(TAG_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int i = 0; i < LANES; i++) addrQ[i] <= reqAddr[i*ADDR_W +: ADDR_W];
    end
  end
endmodule

// File: rtl/coalescer_control.sv
module coalescer_control
  import coalescer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        maskZero,
  input  logic        txnReady,
  input  logic        lastGroup,
  output logic        reqReady,
  output logic        txnValid,
  output coalStrobe_t strobe
);
  coalState_t state, stateNext;

  assign reqReady       = (state == ST_IDLE);
  assign txnValid       = (state == ST_EMIT);
  assign strobe.load    = reqReady && reqValid;
  assign strobe.advance = txnValid && txnReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid && !maskZero) stateNext = ST_EMIT;
      ST_EMIT: if (txnReady && lastGroup) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coalescer_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int TAG_W       = 4,
  localparam int OFF_W      = $clog2(BLOCK_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]        reqMask,
  input  logic [1:0]              reqSize,
  output logic                    txnValid,
  input  logic                    txnReady,
  output logic [ADDR_W-1:0]       txnBlockAddr,
  output logic [LANES-1:0]        txnLaneMask,
  output logic [LANES*OFF_W-1:0]  txnOffsets,
  output logic [1:0]              txnSize,
  output logic [TAG_W-1:0]        txnTag
);
  coalStrobe_t strobe;
  logic        lastGroup;

  coalescer_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .maskZero  (reqMask == '0),
    .txnReady  (txnReady),
    .lastGroup (lastGroup),
    .reqReady  (reqReady),
    .txnValid  (txnValid),
    .strobe    (strobe)
  );

  coalescer_datapath #(
    .LANES (LANES),
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .TAG_W (TAG_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqMask      (reqMask),
    .reqSize      (reqSize),
    .lastGroup    (lastGroup),
    .txnBlockAddr (txnBlockAddr),
    .txnLaneMask  (txnLaneMask),
    .txnOffsets   (txnOffsets),
    .txnSize      (txnSize),
    .txnTag       (txnTag)
  );
endmodule

// File: rtl/coalescer_checker.sv
module coalescer_checker #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int TAG_W  = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic [LANES-1:0]       reqMask,
  input logic [1:0]             reqSize,
  input logic                   txnValid,
  input logic                   txnReady,
  input logic [ADDR_W-1:0]      txnBlockAddr,
  input logic [LANES-1:0]       txnLaneMask,
  input logic [LANES*OFF_W-1:0] txnOffsets,
  input logic [1:0]             txnSize,
  input logic [TAG_W-1:0]       txnTag
);
  logic [LANES-1:0] acceptedMask;
  logic [1:0]       acceptedSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptedMask <= '0;
      acceptedSize <= '0;
    end else if (reqValid && reqReady) begin
      acceptedMask <= reqMask;
      acceptedSize <= reqSize;
    end
  end

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && txnValid));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> (txnValid && $stable(txnBlockAddr) &&
      $stable(txnLaneMask) && $stable(txnOffsets) && $stable(txnTag)));

  assert_tag_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && txnReady) |=> (txnTag == TAG_W'($past(txnTag) + 1'b1)));

  assert_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnLaneMask != '0));

  assert_inactive_R6: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnLaneMask & ~acceptedMask) == '0));

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMask == '0) |=> (reqReady && !txnValid));

  assert_size_R10: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnSize == acceptedSize));

  assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnBlockAddr[OFF_W-1:0] == '0));

  for (genvar g = 0; g < LANES; g++) begin : gOff
    assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
      (txnValid && !txnLaneMask[g]) |-> (txnOffsets[g*OFF_W +: OFF_W] == '0));
  end
endmodule

bind warp_coalescer coalescer_checker #(
  .LANES (LANES),
  .ADDR_W(ADDR_W),
  .OFF_W (OFF_W),
  .TAG_W (TAG_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqMask      (reqMask),
  .reqSize      (reqSize),
  .txnValid     (txnValid),
  .txnReady     (txnReady),
  .txnBlockAddr (txnBlockAddr),
  .txnLaneMask  (txnLaneMask),
  .txnOffsets   (txnOffsets),
  .txnSize      (txnSize),
  .txnTag       (txnTag)
);

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
  localparam int LANES  = 8;
  localparam int ADDR_W = 32;
  localparam int BLOCK  = 64;
  localparam int TAG_W  = 4;
  localparam int OFF_W  = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rstN;
  logic                    reqValid;
  logic                    reqReady;
  logic [LANES*ADDR_W-1:0] reqAddr;
  logic [LANES-1:0]        reqMask;
  logic [1:0]              reqSize;
  logic                    txnValid;
  logic                    txnReady;
  logic [ADDR_W-1:0]       txnBlockAddr;
  logic [LANES-1:0]        txnLaneMask;
  logic [LANES*OFF_W-1:0]  txnOffsets;
  logic [1:0]              txnSize;
  logic [TAG_W-1:0]        txnTag;

  warp_coalescer #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK), .TAG_W(TAG_W)
  ) i_warp_coalescer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqMask(reqMask), .reqSize(reqSize),
    .txnValid(txnValid), .txnReady(txnReady), .txnBlockAddr(txnBlockAddr),
    .txnLaneMask(txnLaneMask), .txnOffsets(txnOffsets), .txnSize(txnSize),
    .txnTag(txnTag)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [TAG_W-1:0] expTag = '0;

  logic [ADDR_W-1:0] stim   [LANES];
  logic [LANES-1:0]  expMask[LANES];
  logic [ADDR_W-1:0] expBlk [LANES];
  int                expCnt;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit isAligned(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return 1'b1;
    if (sz == 2'd1) return (a[0] == 1'b0);
    return (a[1:0] == 2'b00);
  endfunction

  // reference grouping computed from the requirement text
  task automatic buildModel(input logic [LANES-1:0] m, input logic [1:0] sz);
    logic [LANES-1:0] pend;
    pend = m;
    expCnt = 0;
    while (pend != '0) begin
      int lead = 0;
      logic [LANES-1:0] grp;
      bit al;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      al = isAligned(stim[lead], sz);
      grp = '0;
      for (int i = 0; i < LANES; i++) begin
        if (pend[i]) begin
          if (al) grp[i] = isAligned(stim[i], sz) && (stim[i] / BLOCK == stim[lead] / BLOCK);
          else    grp[i] = (i == lead);
        end
      end
      expMask[expCnt] = grp;
      expBlk[expCnt]  = stim[lead] & ~(ADDR_W'(BLOCK - 1));
      pend = pend & ~grp;
      expCnt++;
    end
  endtask

  task automatic runWarp(input logic [LANES-1:0] m, input logic [1:0] sz,
                         input bit stall, input string req);
    int idx = 0;
    int guard = 0;
    for (int i = 0; i < LANES; i++) reqAddr[i*ADDR_W +: ADDR_W] = stim[i];
    reqMask  = m;
    reqSize  = sz;
    reqValid = 1'b1;
    check(reqReady === 1'b1, "R7", "ready before accept", 64'(reqReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    buildModel(m, sz);
    while (idx < expCnt && guard < 200) begin
      bit rdy;
      bit v;
      guard++;
      v = txnValid;
      check(v === 1'b1, "R7", "txnValid while busy", 64'(v), 64'd1);
      check(reqReady === 1'b0, "R7", "reqReady while busy", 64'(reqReady), 64'd0);
      check(txnLaneMask === expMask[idx], req, "lane mask", 64'(txnLaneMask), 64'(expMask[idx]));
      check(txnBlockAddr === expBlk[idx], "R4", "block address", 64'(txnBlockAddr), 64'(expBlk[idx]));
      check(txnTag === expTag, "R9", "tag", 64'(txnTag), 64'(expTag));
      check(txnSize === sz, "R10", "size", 64'(txnSize), 64'(sz));
      for (int l = 0; l < LANES; l++) begin
        logic [OFF_W-1:0] eo;
        eo = expMask[idx][l] ? stim[l][OFF_W-1:0] : '0;
        check(txnOffsets[l*OFF_W +: OFF_W] === eo, "R2", "lane offset",
              64'(txnOffsets[l*OFF_W +: OFF_W]), 64'(eo));
      end
      rdy = stall ? (($urandom % 3) != 0) : 1'b1;
      txnReady = rdy;
      @(posedge clk);
      if (v && rdy) begin
        idx++;
        expTag = expTag + 1'b1;
      end
      @(negedge clk);
    end
    txnReady = 1'b0;
    check(guard < 200, req, "transaction count", 64'(idx), 64'(expCnt));
    check(txnValid === 1'b0, "R7", "txnValid after warp", 64'(txnValid), 64'd0);
    check(reqReady === 1'b1, (expCnt == 0) ? "R6" : "R7", "reqReady after warp",
          64'(reqReady), 64'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int strides[9] = '{0, 1, 2, 3, 4, 8, 16, 40, 64};
    logic [LANES-1:0] masks[5] = '{8'hFF, 8'h01, 8'h80, 8'h5A, 8'hC3};
    rstN = 1'b0;
    reqValid = 1'b0;
    txnReady = 1'b0;
    reqAddr = '0;
    reqMask = '0;
    reqSize = '0;
    repeat (3) @(negedge clk);
    check(reqReady === 1'b1, "R1", "reset reqReady", 64'(reqReady), 64'd1);
    check(txnValid === 1'b0, "R1", "reset txnValid", 64'(txnValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txnTag === '0, "R1", "reset tag", 64'(txnTag), 64'd0);
    check(reqReady === 1'b1, "R1", "idle reqReady", 64'(reqReady), 64'd1);

    // directed: one misaligned lane among aligned neighbours, every 4-byte code
    for (int sz = 2; sz < 4; sz++) begin
      for (int i = 0; i < LANES; i++) stim[i] = 32'h3000 + 32'(4 * i);
      stim[3] = 32'h3002;
      runWarp(8'hFF, 2'(sz), 1'b0, "R5");
    end
    // directed: 2-byte accesses with odd addresses
    for (int i = 0; i < LANES; i++) stim[i] = 32'h4000 + 32'(2 * i + (i % 2));
    runWarp(8'hFF, 2'd1, 1'b1, "R5");

    // directed: empty mask and sparse masks
    for (int i = 0; i < LANES; i++) stim[i] = 32'h5000 + 32'(70 * i);
    runWarp(8'h00, 2'd2, 1'b0, "R6");
    runWarp(8'h00, 2'd0, 1'b1, "R6");
    runWarp(8'h24, 2'd0, 1'b1, "R6");

    // sweep: size x stride x base offset x base region x mask
    for (int sz = 0; sz < 4; sz++)
      for (int s = 0; s < 9; s++)
        for (int bo = 0; bo < 4; bo++)
          for (int region = 0; region < 2; region++)
            for (int mi = 0; mi < 5; mi++) begin
              logic [ADDR_W-1:0] base;
              base = (region == 0) ? 32'h1000 + 32'(bo) : 32'h2000 + 32'd56 + 32'(bo);
              for (int i = 0; i < LANES; i++) stim[i] = base + 32'(strides[s] * i);
              runWarp(masks[mi], 2'(sz), ((s + mi) % 2) == 1, "R3");
            end

    // random addresses in a small window, random masks and sizes
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < LANES; i++) stim[i] = 32'h8000 + ($urandom & 32'h1FF);
      runWarp(LANES'($urandom), 2'($urandom), n % 2 == 0, "R3");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule